// File: doc/BRIEF.md
# Host Register and Interrupt Unit for a Four-Channel Serial Receiver

This block sits between an 8-bit host bus and a serial-word receiver with four receive channels and one transmitter. It holds the host-visible control byte (channel select, transmit programming enable, transmit start, loopback, transmit-interrupt mask). It gathers the "new word" flags of the four channels and the "transmission finished" flag of the transmitter into a status byte. From these it drives a registered, active-low interrupt request. The channel datapaths are outside the block. They appear only as flag inputs, as 24-bit data words with 8-bit labels, and as write strobes toward them.

The host reaches four functions through an active-low chip select, a read/write line and two address bits. Function 0 reads status and writes control. Function 1 holds the transmit clock divider. Function 2 writes per-channel configuration. Function 3 reads received data or loads transmit bytes. A data read walks the three data bytes of the selected channel and then its label. Reading the label retires the channel's status flag.

Every access lasts one clock cycle with `cs_n` low. Read data is combinational from the current state. State changes take effect at the clock edge that ends the access.

Top module: `bus_ctl_irq`

## Requirements
- R1: After synchronous reset, the control byte, the divider and all status bits are 0, `irq_n` is 1, and both the data-read and transmit-byte indices are 0.
- R2: A write to function 0 stores the control byte. Bits 3:0 select channels (`ch_sel`), bit 4 is transmit programming (`tx_prog`), bit 5 is transmit start (`tx_start`), bit 6 is loopback and bit 7 is the transmit-interrupt mask.
- R3: A pulse on `ch_new[i]` sets status bit i (i = 0..3). A read of function 0 returns {`tx_busy`, 0, 0, S4, S3..S0}, so bits 6:5 always read 0.
- R4: A read of function 3 returns, for the lowest-numbered selected channel, data bits 7:0, then 15:8, then 23:16, then the label, and then wraps. Any control write restarts the sequence at data bits 7:0. With no channel selected the read returns 0.
- R5: A read of a channel's label clears that channel's status bit. A `ch_new` pulse in the same cycle wins and leaves the bit set.
- R6: A `tx_done` pulse sets status bit 4 and clears control bit 5. A control write with bit 4 set clears status bit 4 unless `tx_done` arrives in the same cycle.
- R7: `irq_n` is registered. One cycle after any of status bits 3:0 is set, or status bit 4 is set while control bit 7 is 0, it is 0. Otherwise it is 1. Control bit 7 masks only status bit 4.
- R8: `loop_en` is control bit 6 AND control bit 5. A status read (read of function 0) clears control bit 6 and leaves the other control bits unchanged.
- R9: A write to function 1 stores the divider with bit 0 forced to 0. `div_ratio` shows the stored value and a read of function 1 returns it.
- R10: During a write to function 2, `cfg_we` equals the channel select bits and `cfg_data` equals the written byte. At all other times `cfg_we` is 0.
- R11: During a write to function 3 with control bit 4 set, `tx_we` is 1 and `tx_idx` gives the byte slot (0 to 3). The slot advances after each such write and returns to 0 on a control write with bit 4 set. With control bit 4 clear, `tx_we` stays 0.
- R12: While `cs_n` is 1, bus inputs change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_n | input | 1 | Chip select, active low; one cycle per access |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | 2 | Function select |
| wr_data | input | 8 | Host write byte |
| rd_data | output | 8 | Host read byte (0 when not reading) |
| ch_buf | input | 96 | Four 24-bit received data words, channel 0 in the low bits |
| ch_lbl | input | 32 | Four 8-bit received labels, channel 0 in the low bits |
| ch_new | input | 4 | One-cycle pulse per channel: valid new word stored |
| tx_done | input | 1 | One-cycle pulse: transmission finished |
| tx_busy | input | 1 | Transmission in progress |
| ch_sel | output | 4 | Selected receive channels |
| tx_prog | output | 1 | Transmit programming enabled |
| tx_start | output | 1 | Transmit start request |
| loop_en | output | 1 | Route transmit stream into the selected receiver |
| div_ratio | output | 8 | Transmit clock divide ratio (bit 0 is 0) |
| cfg_we | output | 4 | Per-channel configuration write strobe |
| cfg_data | output | 8 | Configuration write byte |
| tx_we | output | 1 | Transmit byte write strobe |
| tx_idx | output | 2 | Transmit byte slot for `tx_we` |
| irq_n | output | 1 | Interrupt request, active low, registered |

## Verification
Assertions check on every cycle that a channel or transmit flag is set the cycle after its event, and that a label read clears only its own flag. They also check that the interrupt output follows the unmasked status one cycle later, that a status read drops the loopback bit, and that an idle bus leaves the control byte alone. The bench scenarios show things a single-cycle property cannot: the byte order of data reads and its restart after a control write, the lowest-channel choice when several channels are selected, and the forced-zero divider bit. They also show the transmit slot numbering, and set-versus-clear priority when a flag arrives on the same cycle as the label read.

// File: rtl/bus_ctl_irq_pkg.sv
// Shared constants and types for the host register and interrupt unit.
// Assumes exactly four channels; the status byte layout depends on it.
package bus_ctl_irq_pkg;
    localparam int DW        = 8;
    localparam int NCH       = 4;
    localparam int BUF_BYTES = 3;
    localparam int BUF_W     = BUF_BYTES * DW;
    localparam int IDX_W     = 2;

    typedef enum logic [1:0] {
        FN_CTLSTAT = 2'b00,
        FN_DIV     = 2'b01,
        FN_CFG     = 2'b10,
        FN_DATA    = 2'b11
    } fn_e;

    // Field order follows the control byte bit positions, bit 7 first.
    typedef struct packed {
        logic           tx_mask;
        logic           loop;
        logic           start;
        logic           prog;
        logic [NCH-1:0] sel;
    } ctl_t;
endpackage

// File: rtl/bus_ctl_irq_ctrl.sv
// Control byte, divider register and transmit byte slot counter.
// Assumes one-cycle decoded strobes from the top; strobes are mutually exclusive.
module bus_ctl_irq_ctrl
    import bus_ctl_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic             stat_rd,
    input  logic             div_wr,
    input  logic             data_wr,
    input  logic [DW-1:0]    wr_data,
    input  logic             tx_done,
    output ctl_t             ctl,
    output logic [DW-1:0]    div,
    output logic             tx_we,
    output logic [IDX_W-1:0] tx_idx
);
    logic prog_set;
    assign prog_set = ctl_wr && wr_data[4];
    assign tx_we    = data_wr && ctl.prog;

    // Control byte: host write, auto-clear of start and loopback bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl <= '0;
        end else if (ctl_wr) begin
            ctl <= ctl_t'(wr_data);
        end else begin
            if (tx_done) ctl.start <= 1'b0;
            if (stat_rd) ctl.loop  <= 1'b0;
        end
    end

    // Divider register; bit 0 is always stored as 0.
    always_ff @(posedge clk) begin
        if (!rst_n)      div <= '0;
        else if (div_wr) div <= {wr_data[DW-1:1], 1'b0};
    end

    // Transmit byte slot: restart on programming enable, advance per byte.
    always_ff @(posedge clk) begin
        if (!rst_n)        tx_idx <= '0;
        else if (prog_set) tx_idx <= '0;
        else if (tx_we)    tx_idx <= tx_idx + 1'b1;
    end

    AST_LOOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !ctl_wr) |=> !ctl.loop);                                      // R8
    AST_START_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done && !ctl_wr) |=> !ctl.start);                                     // R6
    AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_wr) |=> ($stable(ctl.sel) && $stable(ctl.prog) && $stable(ctl.tx_mask))); // R12
    AST_TXIDX_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        prog_set |=> (tx_idx == '0));                                             // R11
endmodule

// File: rtl/bus_ctl_irq_status.sv
// Status flags and registered active-low interrupt request.
// Assumes ch_new and tx_done are single-cycle pulses; set beats clear.
module bus_ctl_irq_status
    import bus_ctl_irq_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] ch_new,
    input  logic [NCH-1:0] rd_clr,
    input  logic           tx_done,
    input  logic           s4_clr,
    input  logic           tx_mask,
    input  logic           tx_busy,
    output logic [DW-1:0]  stat_byte,
    output logic           irq_n
);
    logic [NCH-1:0] s_rx;
    logic           s_tx;

    genvar gi;
    generate
        for (gi = 0; gi < NCH; gi++) begin : g_rx
            // Channel flag: set on new word, clear on label read.
            always_ff @(posedge clk) begin
                if (!rst_n)            s_rx[gi] <= 1'b0;
                else if (ch_new[gi])   s_rx[gi] <= 1'b1;
                else if (rd_clr[gi])   s_rx[gi] <= 1'b0;
            end

            AST_RX_SET: assert property (@(posedge clk) disable iff (!rst_n)
                ch_new[gi] |=> s_rx[gi]);                                       // R3
            AST_RX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
                (rd_clr[gi] && !ch_new[gi]) |=> !s_rx[gi]);                     // R5
        end
    endgenerate

    // Transmit-finished flag.
    always_ff @(posedge clk) begin
        if (!rst_n)       s_tx <= 1'b0;
        else if (tx_done) s_tx <= 1'b1;
        else if (s4_clr)  s_tx <= 1'b0;
    end

    assign stat_byte = {tx_busy, 2'b00, s_tx, s_rx};

    // Registered interrupt so the output never glitches.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_n <= 1'b1;
        else        irq_n <= ~((|s_rx) | (s_tx & ~tx_mask));
    end

    AST_TX_SET: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> s_tx);                                                      // R6
    AST_IRQ_RX: assert property (@(posedge clk) disable iff (!rst_n)
        (|s_rx) |=> !irq_n);                                                    // R7
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|s_rx) && (!s_tx || tx_mask)) |=> irq_n);                            // R7
endmodule

// File: rtl/bus_ctl_irq_rdpath.sv
// Host read multiplexer and received-data byte walker.
// Assumes the lowest-numbered selected channel is the one read.
module bus_ctl_irq_rdpath
    import bus_ctl_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd,
    input  logic [1:0]         addr,
    input  logic               ctl_wr,
    input  logic [NCH-1:0]     sel,
    input  logic [NCH*BUF_W-1:0] ch_buf,
    input  logic [NCH*DW-1:0]  ch_lbl,
    input  logic [DW-1:0]      stat_byte,
    input  logic [DW-1:0]      div,
    output logic [DW-1:0]      rd_data,
    output logic [NCH-1:0]     rd_clr
);
    logic [IDX_W-1:0] rd_idx;
    logic             data_rd;
    logic             has_ch;
    int               pick;
    logic [DW-1:0]    chan_byte;

    assign data_rd = rd && (fn_e'(addr) == FN_DATA);
    assign has_ch  = |sel;

    // Lowest selected channel wins.
    always_comb begin
        pick = 0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (sel[i]) pick = i;
        end
    end

    // Byte of the chosen channel at the current walk position.
    always_comb begin
        if (rd_idx == IDX_W'(BUF_BYTES)) chan_byte = ch_lbl[pick*DW +: DW];
        else chan_byte = ch_buf[pick*BUF_W + int'(rd_idx)*DW +: DW];
    end

    // Read data selection by function.
    always_comb begin
        rd_data = '0;
        if (rd) begin
            unique case (fn_e'(addr))
                FN_CTLSTAT: rd_data = stat_byte;
                FN_DIV:     rd_data = div;
                FN_CFG:     rd_data = '0;
                FN_DATA:    rd_data = has_ch ? chan_byte : '0;
            endcase
        end
    end

    // Walk position: restart on control write, advance per data read.
    always_ff @(posedge clk) begin
        if (!rst_n)       rd_idx <= '0;
        else if (ctl_wr)  rd_idx <= '0;
        else if (data_rd) rd_idx <= rd_idx + 1'b1;
    end

    // Label read retires the chosen channel's flag.
    always_comb begin
        rd_clr = '0;
        if (data_rd && has_ch && rd_idx == IDX_W'(BUF_BYTES)) rd_clr[pick] = 1'b1;
    end

    AST_IDX_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> (rd_idx == '0));                                             // R4
    AST_CLR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rd_clr));                                                      // R5
endmodule

// File: rtl/bus_ctl_irq.sv
// Top: host bus decode tying control, status/interrupt and read path together.
// Assumes one clock per access with cs_n low; outputs toward channels are strobes.
module bus_ctl_irq
    import bus_ctl_irq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_n,
    input  logic                 rw,
    input  logic [1:0]           addr,
    input  logic [DW-1:0]        wr_data,
    output logic [DW-1:0]        rd_data,
    input  logic [NCH*BUF_W-1:0] ch_buf,
    input  logic [NCH*DW-1:0]    ch_lbl,
    input  logic [NCH-1:0]       ch_new,
    input  logic                 tx_done,
    input  logic                 tx_busy,
    output logic [NCH-1:0]       ch_sel,
    output logic                 tx_prog,
    output logic                 tx_start,
    output logic                 loop_en,
    output logic [DW-1:0]        div_ratio,
    output logic [NCH-1:0]       cfg_we,
    output logic [DW-1:0]        cfg_data,
    output logic                 tx_we,
    output logic [IDX_W-1:0]     tx_idx,
    output logic                 irq_n
);
    logic           rd, wr;
    logic           ctl_wr, stat_rd, div_wr, cfg_wr, data_wr;
    ctl_t           ctl;
    logic [DW-1:0]  stat_byte;
    logic [NCH-1:0] rd_clr;
    fn_e            fn;

    assign fn      = fn_e'(addr);
    assign rd      = !cs_n && rw;
    assign wr      = !cs_n && !rw;
    assign ctl_wr  = wr && (fn == FN_CTLSTAT);
    assign stat_rd = rd && (fn == FN_CTLSTAT);
    assign div_wr  = wr && (fn == FN_DIV);
    assign cfg_wr  = wr && (fn == FN_CFG);
    assign data_wr = wr && (fn == FN_DATA);

    assign ch_sel   = ctl.sel;
    assign tx_prog  = ctl.prog;
    assign tx_start = ctl.start;
    assign loop_en  = ctl.loop && ctl.start;
    assign cfg_we   = cfg_wr ? ctl.sel : '0;
    assign cfg_data = wr_data;

    bus_ctl_irq_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .stat_rd(stat_rd),
        .div_wr(div_wr), .data_wr(data_wr), .wr_data(wr_data),
        .tx_done(tx_done), .ctl(ctl), .div(div_ratio),
        .tx_we(tx_we), .tx_idx(tx_idx)
    );

    bus_ctl_irq_status u_stat (
        .clk(clk), .rst_n(rst_n), .ch_new(ch_new), .rd_clr(rd_clr),
        .tx_done(tx_done), .s4_clr(ctl_wr && wr_data[4]), .tx_mask(ctl.tx_mask),
        .tx_busy(tx_busy), .stat_byte(stat_byte), .irq_n(irq_n)
    );

    bus_ctl_irq_rdpath u_rd (
        .clk(clk), .rst_n(rst_n), .rd(rd), .addr(addr), .ctl_wr(ctl_wr),
        .sel(ctl.sel), .ch_buf(ch_buf), .ch_lbl(ch_lbl), .stat_byte(stat_byte),
        .div(div_ratio), .rd_data(rd_data), .rd_clr(rd_clr)
    );

    AST_CFG_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (cfg_we == '0 && !tx_we));                                     // R10
endmodule

// File: tb/sim_bus_ctl_irq.sv
`timescale 1ns/1ps
module sim_bus_ctl_irq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, rw = 1'b1;
    logic [1:0]  addr = 2'd0;
    logic [7:0]  wr_data = 8'd0;
    logic [7:0]  rd_data;
    logic [95:0] ch_buf;
    logic [31:0] ch_lbl;
    logic [3:0]  ch_new = 4'd0;
    logic        tx_done = 1'b0, tx_busy = 1'b0;
    logic [3:0]  ch_sel, cfg_we;
    logic        tx_prog, tx_start, loop_en, tx_we, irq_n;
    logic [7:0]  div_ratio, cfg_data;
    logic [1:0]  tx_idx;

    int n_chk = 0, n_bad = 0;
    logic [7:0] q;
    logic       s_txwe;
    logic [1:0] s_txidx;
    logic [3:0] s_cfgwe;
    logic [7:0] s_cfgdata;

    always #2.5 clk = ~clk;

    bus_ctl_irq u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rw(rw), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .ch_buf(ch_buf), .ch_lbl(ch_lbl),
        .ch_new(ch_new), .tx_done(tx_done), .tx_busy(tx_busy), .ch_sel(ch_sel),
        .tx_prog(tx_prog), .tx_start(tx_start), .loop_en(loop_en),
        .div_ratio(div_ratio), .cfg_we(cfg_we), .cfg_data(cfg_data),
        .tx_we(tx_we), .tx_idx(tx_idx), .irq_n(irq_n)
    );

    // {rw, addr, wdata, check, expected}
    localparam logic [19:0] VEC [12] = '{
        {1'b0, 2'd0, 8'h04, 1'b0, 8'h00},
        {1'b0, 2'd1, 8'h25, 1'b0, 8'h00},
        {1'b1, 2'd1, 8'h00, 1'b1, 8'h24},
        {1'b1, 2'd3, 8'h00, 1'b1, 8'h21},
        {1'b1, 2'd3, 8'h00, 1'b1, 8'h22},
        {1'b1, 2'd3, 8'h00, 1'b1, 8'h23},
        {1'b1, 2'd3, 8'h00, 1'b1, 8'hA2},
        {1'b1, 2'd3, 8'h00, 1'b1, 8'h21},
        {1'b0, 2'd0, 8'h03, 1'b0, 8'h00},
        {1'b1, 2'd3, 8'h00, 1'b1, 8'h01},
        {1'b1, 2'd0, 8'h00, 1'b1, 8'h00},
        {1'b1, 2'd2, 8'h00, 1'b1, 8'h00}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic bus(input logic r, input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cs_n = 1'b0; rw = r; addr = a; wr_data = d;
        #1;
        q = rd_data; s_txwe = tx_we; s_txidx = tx_idx; s_cfgwe = cfg_we; s_cfgdata = cfg_data;
        @(posedge clk); #1;
        cs_n = 1'b1; rw = 1'b1;
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic pulse_new(input logic [3:0] m);
        @(negedge clk); ch_new = m;
        @(negedge clk); ch_new = 4'd0;
    endtask

    task automatic pulse_done();
        @(negedge clk); tx_done = 1'b1;
        @(negedge clk); tx_done = 1'b0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got hung expected done");
        finish_run();
    end

    initial begin
        for (int c = 0; c < 4; c++) begin
            for (int k = 0; k < 3; k++) ch_buf[c*24 + k*8 +: 8] = 8'(16*c + k + 1);
            ch_lbl[c*8 +: 8] = 8'(8'hA0 + c);
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        check("R1 irq_n", {7'd0, irq_n}, 8'd1);
        check("R1 ch_sel", {4'd0, ch_sel}, 8'd0);
        check("R1 div", div_ratio, 8'd0);
        check("R1 start/loop", {6'd0, tx_start, loop_en}, 8'd0);
        bus(1'b1, 2'd0, 8'd0); check("R1 status", q, 8'h00);

        // Table walk: R2 R4 R9 R3
        for (int i = 0; i < 12; i++) begin
            bus(VEC[i][19], VEC[i][18:17], VEC[i][16:9]);
            if (VEC[i][8]) check("R4/R9/R3 vector", q, VEC[i][7:0]);
        end
        check("R2 ch_sel", {4'd0, ch_sel}, 8'h03);
        check("R9 div_ratio", div_ratio, 8'h24);

        // R3/R7 channel flag raises interrupt
        pulse_new(4'b1000);
        tick();
        check("R7 irq on rx", {7'd0, irq_n}, 8'd0);
        bus(1'b1, 2'd0, 8'd0); check("R3 status ch3", q, 8'h08);

        // R4/R5 walk of channel 3, label clears flag
        bus(1'b0, 2'd0, 8'h08);
        bus(1'b1, 2'd3, 8'd0); check("R4 ch3 byte0", q, 8'h31);
        bus(1'b1, 2'd3, 8'd0); check("R4 ch3 byte1", q, 8'h32);
        bus(1'b1, 2'd3, 8'd0); check("R4 ch3 byte2", q, 8'h33);
        bus(1'b1, 2'd3, 8'd0); check("R4 ch3 label", q, 8'hA3);
        tick();
        check("R5 irq released", {7'd0, irq_n}, 8'd1);
        bus(1'b1, 2'd0, 8'd0); check("R5 status clear", q, 8'h00);

        // R6/R7 transmit finished
        bus(1'b0, 2'd0, 8'h20);
        check("R2 tx_start", {7'd0, tx_start}, 8'd1);
        pulse_done();
        check("R6 start dropped", {7'd0, tx_start}, 8'd0);
        tick();
        check("R7 irq on tx", {7'd0, irq_n}, 8'd0);
        bus(1'b1, 2'd0, 8'd0); check("R6 status S4", q, 8'h10);
        bus(1'b0, 2'd0, 8'h80);
        tick();
        check("R7 S4 masked", {7'd0, irq_n}, 8'd1);
        bus(1'b1, 2'd0, 8'd0); check("R6 S4 kept under mask", q, 8'h10);
        pulse_new(4'b0001);
        tick();
        check("R7 rx not maskable", {7'd0, irq_n}, 8'd0);
        bus(1'b0, 2'd0, 8'h81);
        for (int k = 0; k < 4; k++) bus(1'b1, 2'd3, 8'd0);
        tick();
        check("R7 masked S4 only", {7'd0, irq_n}, 8'd1);
        bus(1'b0, 2'd0, 8'h10);
        bus(1'b1, 2'd0, 8'd0); check("R6 S4 cleared by prog", q, 8'h00);

        // R3 busy bit
        tx_busy = 1'b1;
        bus(1'b1, 2'd0, 8'd0); check("R3 busy bit", q, 8'h80);
        tx_busy = 1'b0;

        // R11 transmit byte slots
        bus(1'b0, 2'd3, 8'h11); check("R11 slot0", {6'd0, s_txwe, 1'b0} | {6'd0, s_txidx}, 8'h02);
        bus(1'b0, 2'd3, 8'h12); check("R11 slot1", {5'd0, s_txwe, s_txidx}, 8'h05);
        bus(1'b0, 2'd0, 8'h10);
        bus(1'b0, 2'd3, 8'h13); check("R11 slot restart", {5'd0, s_txwe, s_txidx}, 8'h04);
        bus(1'b0, 2'd0, 8'h00);
        bus(1'b0, 2'd3, 8'h14); check("R11 no prog", {7'd0, s_txwe}, 8'd0);

        // R8 loopback
        bus(1'b0, 2'd0, 8'h62);
        check("R8 loop_en", {7'd0, loop_en}, 8'd1);
        bus(1'b1, 2'd0, 8'd0);
        check("R8 loop cleared", {6'd0, loop_en, tx_start}, 8'h01);
        check("R8 sel kept", {4'd0, ch_sel}, 8'h02);

        // R10 configuration strobe
        bus(1'b0, 2'd0, 8'h05);
        bus(1'b0, 2'd2, 8'h5A);
        check("R10 cfg_we", {4'd0, s_cfgwe}, 8'h05);
        check("R10 cfg_data", s_cfgdata, 8'h5A);
        #1 check("R10 cfg idle", {4'd0, cfg_we}, 8'h00);

        // R12 deselected bus is ignored
        @(negedge clk); cs_n = 1'b1; rw = 1'b0; addr = 2'd1; wr_data = 8'hFE;
        @(negedge clk); addr = 2'd0; wr_data = 8'h0F;
        @(negedge clk); rw = 1'b1;
        bus(1'b1, 2'd1, 8'd0); check("R12 div unchanged", q, 8'h24);
        check("R12 sel unchanged", {4'd0, ch_sel}, 8'h05);

        // R5 set beats clear on the same cycle
        bus(1'b0, 2'd0, 8'h01);
        for (int k = 0; k < 3; k++) bus(1'b1, 2'd3, 8'd0);
        @(negedge clk);
        cs_n = 1'b0; rw = 1'b1; addr = 2'd3; ch_new = 4'b0001;
        @(posedge clk); #1;
        cs_n = 1'b1; ch_new = 4'd0;
        bus(1'b1, 2'd0, 8'd0); check("R5 set wins", q, 8'h01);

        finish_run();
    end
endmodule